// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Master

This block is a bit-level master for a three-wire serial EEPROM that holds 64 words of 16 bits. It drives the chip-select, serial-clock and serial-data-in pins and samples the serial-data-out pin. A request port carries a read or write flag, a 6-bit word address and 16 bits of write data. The block replies with read data, a one-cycle done pulse and, for writes, a timeout flag.

Every change on the pins waits for a tick from a programmable half-period counter, so the whole transaction is paced at one pin step per interval. A read selects the device, sends its command frame, clocks in 16 data bits and ends with a standby pulse. A write runs a fixed chain. It sends the write-enable command, applies a standby pulse and sends the write frame. It then applies a second standby pulse and polls data-out for completion. After a final standby pulse it sends write-disable and cleans up. The enable and disable frames consist of a 5-bit opcode followed by four zero bits.

Top module: `uw_eeprom_master`

## Requirements
- R1: After reset, ready is 1 and chip select, serial clock and data-in are all 0. Whenever the block is idle, serial clock and data-in are 0.
- R2: A request is taken only while ready is 1. A request made while a transaction runs has no effect on the device contents.
- R3: Two successive changes of the pin vector {cs, sk, di} are never closer than HALF_CYC clock cycles.
- R4: Each transaction first drives sk and di low and then raises cs. Each outgoing bit is placed on di and followed by one sk high step and one sk low step. di returns to 0 after the last bit. A read frame is 3'b110 followed by the 6-bit address, MSB first.
- R5: A read captures 16 bits MSB first. Each bit is taken from data-out at the end of the sk-high interval. di stays 0 during the capture. rd_data holds the word when done pulses.
- R6: A write first sends the enable frame 5'b10011 followed by 4'b0000. After a standby pulse it sends 3'b101, the 6-bit address and the 16 data bits, all MSB first.
- R7: A standby pulse is four steps in this order: cs and sk low, then sk high, then cs high, then sk low.
- R8: After the write frame and a standby pulse, data-out is polled once per interval. The first high sample ends the poll. If POLL_MAX polls all read low, the transaction is marked as timed out.
- R9: After the poll, the block applies a standby pulse and sends the disable frame 5'b10000 followed by 4'b0000. It then drops cs and di and issues one sk pulse. The block does this on a timeout as well.
- R10: done is a single-cycle pulse. timeout_err is 1 only in the done cycle of a write whose poll timed out.
- R11: A read ends with a standby pulse, which leaves cs at 1 and sk at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when ready is 1 |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 6 | Word address |
| req_wdata | input | 16 | Data for a write |
| ready | output | 1 | Idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Word captured by the last read |
| timeout_err | output | 1 | Write poll expired, valid with done |
| ee_cs | output | 1 | Device chip select |
| ee_sk | output | 1 | Device serial clock |
| ee_di | output | 1 | Serial data to the device |
| ee_do | input | 1 | Serial data from the device |

## Verification
A pin-level device model in the bench decodes the start bit, the opcode and the address from the pins. It only commits a write if enable was received first, so a write frame that is malformed or lacks enable shows up as a wrong word on a later read. Random reads and writes run alongside directed words at address 0 and address 63 and with all-ones, all-zeros and alternating data. These patterns separate bit-order and address-field faults from data-path faults. The model can hold busy for 190 intervals, which must still pass, or for 215 intervals or forever, which must time out. Comparing these cases checks where the poll window ends, and in every case the bench checks that disable and cleanup still took place.

// File: rtl/uw_pkg.sv
package uw_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;
  localparam int OP_W   = 3;
  localparam int CMD_W  = OP_W + ADDR_W;
  localparam int FRM_W  = CMD_W + DATA_W;
  localparam int CNT_W  = $clog2(FRM_W + 1);

  localparam logic [2:0] OPC_RD = 3'b110;
  localparam logic [2:0] OPC_WR = 3'b101;
  localparam logic [4:0] OPC_EN = 5'b10011;
  localparam logic [4:0] OPC_DS = 5'b10000;

  typedef enum logic [2:0] {
    SG_SETUP, SG_SHIFT, SG_CAPT, SG_STBY, SG_POLL, SG_CLEAN, SG_FIN
  } seg_e;

  function automatic seg_e seg_at(input logic wr, input logic [3:0] idx);
    seg_e s;
    if (!wr) begin
      case (idx)
        4'd0: s = SG_SETUP;
        4'd1: s = SG_SHIFT;
        4'd2: s = SG_CAPT;
        4'd3: s = SG_STBY;
        default: s = SG_FIN;
      endcase
    end else begin
      case (idx)
        4'd0: s = SG_SETUP;
        4'd1: s = SG_SHIFT;
        4'd2: s = SG_STBY;
        4'd3: s = SG_SHIFT;
        4'd4: s = SG_STBY;
        4'd5: s = SG_POLL;
        4'd6: s = SG_STBY;
        4'd7: s = SG_SHIFT;
        4'd8: s = SG_CLEAN;
        default: s = SG_FIN;
      endcase
    end
    return s;
  endfunction

  function automatic logic [FRM_W-1:0] frame_at(input logic wr, input logic [3:0] idx,
                                                 input logic [ADDR_W-1:0] a,
                                                 input logic [DATA_W-1:0] d);
    logic [CMD_W-1:0] en_f;
    logic [CMD_W-1:0] ds_f;
    en_f = {OPC_EN, {(ADDR_W-2){1'b0}}};
    ds_f = {OPC_DS, {(ADDR_W-2){1'b0}}};
    if (!wr)             return {OPC_RD, a, {DATA_W{1'b0}}};
    else if (idx == 4'd3) return {OPC_WR, a, d};
    else if (idx == 4'd7) return {ds_f, {DATA_W{1'b0}}};
    else                 return {en_f, {DATA_W{1'b0}}};
  endfunction

  function automatic logic [CNT_W-1:0] len_at(input logic wr, input logic [3:0] idx);
    if (seg_at(wr, idx) == SG_CAPT) return CNT_W'(DATA_W);
    if (wr && idx == 4'd3)          return CNT_W'(FRM_W);
    return CNT_W'(CMD_W);
  endfunction
endpackage

// File: rtl/uw_pacer.sv
module uw_pacer #(
  parameter int HALF_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(HALF_CYC + 1);
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !run)  cnt <= CW'(HALF_CYC - 1);
    else if (cnt == '0)  cnt <= CW'(HALF_CYC - 1);
    else                 cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/uw_poll_guard.sv
module uw_poll_guard #(
  parameter int POLL_MAX = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last,
  output logic [$clog2(POLL_MAX+1)-1:0] count
);
  localparam int PW = $clog2(POLL_MAX + 1);

  assign last = (count == PW'(POLL_MAX - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) count <= '0;
    else if (inc)      count <= count + 1'b1;
  end
endmodule

// File: rtl/uw_eeprom_master.sv
module uw_eeprom_master
  import uw_pkg::*;
#(
  parameter int HALF_CYC = 10000,
  parameter int POLL_MAX = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [5:0]  req_addr,
  input  logic [15:0] req_wdata,
  output logic        ready,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        timeout_err,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do
);
  localparam int PW = $clog2(POLL_MAX + 1);

  logic              busy, is_wr, tout;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q, cap;
  logic [3:0]        seg_idx, nidx;
  logic [1:0]        ph;
  logic [FRM_W-1:0]  sreg;
  logic [CNT_W-1:0]  bits;
  logic              tick, poll_last;
  logic [PW-1:0]     poll_cnt;
  seg_e              seg;

  assign seg   = seg_at(is_wr, seg_idx);
  assign nidx  = seg_idx + 4'd1;
  assign ready = !busy;

  // event wires shared with the checker
  logic accept, in_capt, stby_cs_step, poll_step;
  assign accept       = req_valid && !busy;
  assign in_capt      = busy && (seg == SG_CAPT);
  assign stby_cs_step = busy && tick && (seg == SG_STBY) && (ph == 2'd2);
  assign poll_step    = busy && tick && (seg == SG_POLL);

  uw_pacer #(.HALF_CYC(HALF_CYC)) u_pace (
    .clk(clk), .rst_n(rst_n), .run(busy && seg != SG_FIN), .tick(tick)
  );

  uw_poll_guard #(.POLL_MAX(POLL_MAX)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(accept),
    .inc(poll_step && !ee_do && !poll_last),
    .last(poll_last), .count(poll_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; is_wr <= 1'b0; tout <= 1'b0;
      addr_q <= '0; wd_q <= '0; cap <= '0; rd_data <= '0;
      seg_idx <= '0; ph <= '0; sreg <= '0; bits <= '0;
      done <= 1'b0; timeout_err <= 1'b0;
      ee_cs <= 1'b0; ee_sk <= 1'b0; ee_di <= 1'b0;
    end else begin
      done        <= 1'b0;
      timeout_err <= 1'b0;
      if (accept) begin
        busy <= 1'b1; is_wr <= req_write; addr_q <= req_addr; wd_q <= req_wdata;
        seg_idx <= '0; ph <= '0; tout <= 1'b0; cap <= '0;
      end else if (busy && seg == SG_FIN) begin
        busy        <= 1'b0;
        done        <= 1'b1;
        timeout_err <= tout;
        if (!is_wr) rd_data <= cap;
      end else if (tick) begin
        case (seg)
          SG_SETUP: begin
            if (ph == 2'd0) begin ee_sk <= 1'b0; ee_di <= 1'b0; ph <= 2'd1; end
            else begin
              ee_cs <= 1'b1;
              seg_idx <= nidx; ph <= '0;
              sreg <= frame_at(is_wr, nidx, addr_q, wd_q); bits <= len_at(is_wr, nidx);
            end
          end
          SG_SHIFT: begin
            case (ph)
              2'd0: if (bits == '0) begin
                      ee_di <= 1'b0;
                      seg_idx <= nidx; ph <= '0;
                      sreg <= frame_at(is_wr, nidx, addr_q, wd_q); bits <= len_at(is_wr, nidx);
                    end else begin
                      ee_di <= sreg[FRM_W-1]; ph <= 2'd1;
                    end
              2'd1: begin ee_sk <= 1'b1; ph <= 2'd2; end
              default: begin
                ee_sk <= 1'b0; sreg <= sreg << 1; bits <= bits - 1'b1; ph <= 2'd0;
              end
            endcase
          end
          SG_CAPT: begin
            if (ph == 2'd0) begin ee_sk <= 1'b1; ee_di <= 1'b0; ph <= 2'd1; end
            else begin
              cap <= {cap[DATA_W-2:0], ee_do};
              ee_sk <= 1'b0; bits <= bits - 1'b1;
              if (bits == CNT_W'(1)) begin seg_idx <= nidx; ph <= '0; end
              else ph <= 2'd0;
            end
          end
          SG_STBY: begin
            case (ph)
              2'd0: begin ee_cs <= 1'b0; ee_sk <= 1'b0; ph <= 2'd1; end
              2'd1: begin ee_sk <= 1'b1; ph <= 2'd2; end
              2'd2: begin ee_cs <= 1'b1; ph <= 2'd3; end
              default: begin
                ee_sk <= 1'b0;
                seg_idx <= nidx; ph <= '0;
                sreg <= frame_at(is_wr, nidx, addr_q, wd_q); bits <= len_at(is_wr, nidx);
              end
            endcase
          end
          SG_POLL: begin
            if (ee_do || poll_last) begin
              if (!ee_do) tout <= 1'b1;
              seg_idx <= nidx; ph <= '0;
              sreg <= frame_at(is_wr, nidx, addr_q, wd_q); bits <= len_at(is_wr, nidx);
            end
          end
          SG_CLEAN: begin
            case (ph)
              2'd0: begin ee_cs <= 1'b0; ee_di <= 1'b0; ph <= 2'd1; end
              2'd1: begin ee_sk <= 1'b1; ph <= 2'd2; end
              default: begin ee_sk <= 1'b0; seg_idx <= nidx; ph <= '0; end
            endcase
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/uw_eeprom_chk.sv
module uw_eeprom_chk #(
  parameter int POLL_MAX = 200
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ready,
  input logic       done,
  input logic       timeout_err,
  input logic       ee_cs,
  input logic       ee_sk,
  input logic       ee_di,
  input logic       tick,
  input logic       in_capt,
  input logic       stby_cs_step,
  input logic       is_wr,
  input logic [5:0] addr_q,
  input logic [$clog2(POLL_MAX+1)-1:0] poll_cnt
);
  // R1
  idle_pins_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!ee_sk && !ee_di));
  // R2
  busy_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && $past(!ready)) |-> $stable(addr_q));
  // R3
  pin_move_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({ee_cs, ee_sk, ee_di} != $past({ee_cs, ee_sk, ee_di})) |-> $past(tick));
  // R5
  capt_di_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_capt |-> !ee_di);
  // R7
  stby_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stby_cs_step |=> (ee_cs && ee_sk));
  // R8
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt < ($clog2(POLL_MAX+1))'(POLL_MAX));
  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  err_with_write_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> (done && is_wr));
endmodule

bind uw_eeprom_master uw_eeprom_chk #(.POLL_MAX(POLL_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .done(done), .timeout_err(timeout_err),
  .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .tick(tick), .in_capt(in_capt),
  .stby_cs_step(stby_cs_step), .is_wr(is_wr), .addr_q(addr_q), .poll_cnt(poll_cnt)
);

// File: tb/tb_uw_eeprom_master.sv
`timescale 1ns/1ps
module tb_uw_eeprom_master;
  localparam int HALF = 4;
  localparam int PMAX = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [5:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic ready, done, timeout_err, ee_cs, ee_sk, ee_di, ee_do;
  logic [15:0] rd_data;

  always #2.5 clk = ~clk;

  uw_eeprom_master #(.HALF_CYC(HALF), .POLL_MAX(PMAX)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .done(done),
    .rd_data(rd_data), .timeout_err(timeout_err), .ee_cs(ee_cs), .ee_sk(ee_sk),
    .ee_di(ee_di), .ee_do(ee_do)
  );

  int n_vec = 0, n_bad = 0;
  logic [15:0] shadow [64];

  function automatic logic [15:0] init_word(input int a);
    return 16'((a * 16'h0313) ^ 16'h5A0F);
  endfunction

  // ---------------- pin-level device model ----------------
  logic [15:0] mem [64];
  logic p_cs = 0, p_sk = 0, p_di = 0;
  int cyc = 0, last_chg = 0, have_chg = 0;
  int bcnt = 0, rd_mode = 0, rd_idx = 0;
  logic [24:0] sh = '0;
  logic [15:0] rd_word = '0;
  logic we = 1'b0;
  logic do_r = 1'b0, status = 1'b0;
  int busy_cnt = 0, busy_len = 20 * HALF;
  logic busy_inf = 1'b0;
  int pace_bad = 0, rd_di_bad = 0, stby_bad = 0, stby_seen = 0, trk = 0;

  assign ee_do = (status && ee_cs) ? (busy_cnt == 0 && !busy_inf) : do_r;

  initial for (int i = 0; i < 64; i++) begin mem[i] = init_word(i); shadow[i] = init_word(i); end

  always @(posedge clk) begin
    cyc++;
    p_cs <= ee_cs; p_sk <= ee_sk; p_di <= ee_di;
    if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    if (rst_n && ({ee_cs, ee_sk, ee_di} != {p_cs, p_sk, p_di})) begin
      if (have_chg != 0 && cyc - last_chg < HALF) pace_bad++;
      last_chg = cyc; have_chg = 1;
      if (trk > 0) begin
        case (trk)
          1: if (!(ee_cs == 0 && ee_sk == 1)) stby_bad++;
          2: if (!(ee_cs == 1 && ee_sk == 1)) stby_bad++;
          default: if (!(ee_cs == 1 && ee_sk == 0)) stby_bad++;
        endcase
        trk = (trk == 3) ? 0 : trk + 1;
        if (trk == 0) stby_seen++;
      end
    end
    if (rst_n && p_cs && !ee_cs) begin
      if (bcnt == 25) begin
        if (we) mem[sh[21:16]] = sh[15:0];
        busy_cnt <= busy_len; status <= 1'b1;
        if (ee_sk == 0) trk = 1;
      end
      bcnt = 0; rd_mode = 0; do_r <= 1'b0;
    end else if (rst_n && ee_cs && ee_sk && !p_sk) begin
      if (rd_mode != 0) begin
        if (ee_di) rd_di_bad++;
        do_r <= rd_word[15 - rd_idx];
        rd_idx++;
        if (rd_idx == 16) rd_mode = 0;
      end else if (!(bcnt == 0 && !ee_di) && bcnt < 25) begin
        status <= 1'b0;
        sh = {sh[23:0], ee_di};
        bcnt++;
        if (bcnt == 9) begin
          case (sh[7:6])
            2'b10: begin rd_mode = 1; rd_idx = 0; rd_word = mem[sh[5:0]]; bcnt = 0; end
            2'b00: begin
              if (sh[5:4] == 2'b11) we = 1'b1;
              else if (sh[5:4] == 2'b00) we = 1'b0;
              bcnt = 0;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic issue(input logic wr, input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output logic [15:0] rd, output logic er);
    int n = 0;
    while (!done) begin
      @(negedge clk);
      n++;
      if (n > 6000) begin
        chk(1'b0, "watchdog", n, 0);
        finish_run();
      end
    end
    rd = rd_data; er = timeout_err;
    @(negedge clk);
    // R10: done lasts one cycle, error flag clears with it
    chk(!done && !timeout_err, "R10 pulse", {done, timeout_err}, 0);
  endtask

  task automatic do_write(input logic [5:0] a, input logic [15:0] d, input logic exp_err);
    logic [15:0] r; logic e;
    issue(1'b1, a, d);
    wait_done(r, e);
    shadow[a] = d;
    chk(e == exp_err, "R8 timeout flag", e, exp_err);
    // R9: disable was sent and cleanup left cs and clock low
    chk(we == 1'b0 && !ee_cs && !ee_sk && !ee_di, "R9 disable/cleanup",
        {we, ee_cs, ee_sk, ee_di}, 0);
  endtask

  task automatic do_read(input logic [5:0] a);
    logic [15:0] r; logic e;
    issue(1'b0, a, 16'h0);
    wait_done(r, e);
    // R4 R5: frame decoded by the model and word returned MSB first
    chk(r == shadow[a], "R5 read data", r, shadow[a]);
    chk(e == 1'b0, "R10 no error on read", e, 0);
    // R11: standby leaves cs high, sk low
    chk(ee_cs && !ee_sk, "R11 read end", {ee_cs, ee_sk}, 2'b10);
  endtask

  initial begin
    #(150000 * 5);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int seed_v;
    logic [15:0] r; logic e;
    seed_v = $urandom(32'd91);
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(ready && !ee_cs && !ee_sk && !ee_di && !done && !timeout_err, "R1 reset",
        {ready, ee_cs, ee_sk, ee_di, done, timeout_err}, 6'b100000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready, "R1 ready after reset", ready, 1);

    // R6: directed corner words and addresses
    do_write(6'd0, 16'hFFFF, 1'b0);
    do_write(6'd63, 16'h0000, 1'b0);
    do_write(6'd21, 16'hAAAA, 1'b0);
    do_read(6'd0);
    do_read(6'd63);
    do_read(6'd21);
    do_read(6'd42);

    // random mix
    for (int k = 0; k < 24; k++) begin
      logic [5:0] a;
      a = 6'($urandom);
      busy_len = (1 + int'($urandom % 40)) * HALF;
      if ($urandom % 2 == 0) do_write(a, 16'($urandom), 1'b0);
      else do_read(a);
    end

    // R2: request while busy is ignored
    issue(1'b1, 6'd10, 16'h1234);
    repeat (40) @(negedge clk);
    chk(!ready, "R2 busy", ready, 0);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 6'd11; req_wdata = 16'hDEAD;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(r, e);
    shadow[10] = 16'h1234;
    do_read(6'd11);
    do_read(6'd10);

    // R8: busy near the end of the window still completes
    busy_len = 190 * HALF;
    do_write(6'd5, 16'h0F0F, 1'b0);
    // R8 R9: busy past the window times out, cleanup still runs
    busy_len = 215 * HALF;
    do_write(6'd6, 16'hC3C3, 1'b1);
    busy_inf = 1'b1;
    do_write(6'd7, 16'h7E81, 1'b1);
    busy_inf = 1'b0;
    busy_len = 2 * HALF;
    do_read(6'd5);
    do_read(6'd6);

    // R3 R5 R7: pin-level monitors
    chk(pace_bad == 0, "R3 pacing", pace_bad, 0);
    chk(rd_di_bad == 0, "R5 di low in capture", rd_di_bad, 0);
    chk(stby_bad == 0 && stby_seen > 0, "R7 standby order", stby_bad, 0);
    finish_run();
  end
endmodule